// File: doc/BRIEF.md
# Pause-Width Bit Modulator

This block serialises a reader-to-card frame of up to 32 bits onto one carrier-control line. The line idles high, which means carrier on. Each bit opens with a fixed carrier-off pause. A carrier-on interval follows, and its length carries the bit value, so a bit is told apart by its total duration. Every bit is whitened before it is sent: it is XORed with a keystream bit supplied from outside. The block asks for the next keystream bit with a one-clock pulse after each bit.

Time is counted in ticks, which are single clock cycles qualified by a tick enable. Before the first bit, the block holds the line high until a fixed gap has passed since the previous frame ended. After the last bit it adds a closing pause. When that pause ends, the block raises a done pulse and captures the tick count in a timestamp register, so that a receive path can schedule its own wait from the same reference. A host loads a frame word and a bit count with a start strobe and then waits for the done pulse.

Top module: `pause_bit_modulator`

## Requirements
- R1: After reset `carrier_o` is 1, `ks_adv_o` and `done_o` are 0, and `eof_ts_o` is 0.
- R2: Every bit, and the closing mark, begins with `carrier_o` at 0 for exactly 30 ticks.
- R3: A bit whose transmitted value is 1 lasts 150 ticks in total (30 low, then 120 high). A bit whose transmitted value is 0 lasts 90 ticks (30 low, then 60 high).
- R4: Bits are sent from `frame_i` bit 0 upward, one bit per bit period, `nbits_i` bits in all.
- R5: The transmitted value of bit i is `frame_i[i]` XOR `ks_bit_i`, sampled when that bit's pause ends. `ks_adv_o` pulses high for one clock after each bit, which gives exactly one pulse per bit.
- R6: The first pause of a frame starts exactly 330 ticks after the previous frame's end when the start came earlier than that. If the gap has already elapsed, the first pause starts on the first tick after the start is accepted (two clocks after the strobe cycle when every cycle is a tick).
- R7: After the last bit, a 30-tick low pause is followed by the line returning high. `done_o` is high for exactly one clock, in the same cycle as that rise.
- R8: `eof_ts_o` takes the running tick count at each frame end. For frames sent back to back, it therefore advances by 330 plus the sum of the bit durations plus 30.
- R9: A start strobe that arrives while a frame is in progress has no effect on that frame and does not queue a further frame.
- R10: A bit count of 0 sends only the leading gap and the closing pause, with no `ks_adv_o` pulse.
- R11: All durations are counted only in cycles where `tick_en_i` is 1. With one tick every 3 clocks, every segment is 3 times as long in clocks.
- R12: A bit count above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Time-base tick qualifier |
| start_i | input | 1 | Start strobe, taken only when idle |
| frame_i | input | 32 | Frame word, bit 0 sent first |
| nbits_i | input | 6 | Number of bits to send (0 to 32, larger values clamp) |
| ks_bit_i | input | 1 | Current keystream bit |
| carrier_o | output | 1 | Carrier control, 1 = carrier on |
| ks_adv_o | output | 1 | One-clock request to advance the keystream |
| done_o | output | 1 | One-clock pulse at frame end |
| eof_ts_o | output | 32 | Tick count captured at the last frame end |

## Verification
The bench records every high and low run on the carrier line and decodes the frame from those run lengths. It compares each bit with the data word XORed with its own keystream model, and that model advances only on the block's request pulses. An off-by-one in a tick counter would show up as a 29- or 31-tick pause or a 59/61-tick mark. Sampling the keystream on the wrong side of the advance would flip decoded bits. A gap counted from the start strobe instead of from the previous frame's end would break the exact 330-tick spacing and the timestamp delta.

Further directed cases cover the following:
- A zero-length frame.
- A clamped oversize count.
- A start strobe injected mid-frame, where a design that accepted it would corrupt the frame or send a second one.
- A slowed tick rate, which catches any counter that advances on plain clocks.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP   = 3'd1,
    ST_PAUSE = 3'd2,
    ST_MARK  = 3'd3,
    ST_TAIL  = 3'd4
  } pbm_state_e;

endpackage

// File: rtl/pbm_timebase.sv
module pbm_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en_i,
  input  logic            frame_end_i,
  output logic [TS_W-1:0] eof_ts_o
);

  logic [TS_W-1:0] tick_cnt_q, tick_cnt_d;
  logic [TS_W-1:0] eof_q, eof_d;

  always_comb begin
    tick_cnt_d = tick_cnt_q;
    eof_d      = eof_q;
    if (tick_en_i) begin
      tick_cnt_d = tick_cnt_q + TS_W'(1);
    end
    if (frame_end_i) begin
      eof_d = tick_cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt_q <= '0;
      eof_q      <= '0;
    end else begin
      tick_cnt_q <= tick_cnt_d;
      eof_q      <= eof_d;
    end
  end

  assign eof_ts_o = eof_q;

  AST_STAMP_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eof_q) |-> $past(frame_end_i)); // R8

endmodule

// File: rtl/pbm_gap_guard.sv
module pbm_gap_guard #(
  parameter int TICK_GAP = 330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic frame_end_i,
  output logic gap_ok_o
);

  localparam int GAP_W = (TICK_GAP > 2) ? $clog2(TICK_GAP) : 1;
  localparam logic [GAP_W-1:0] SAT = GAP_W'(TICK_GAP - 1);

  logic [GAP_W-1:0] since_q, since_d;

  always_comb begin
    since_d = since_q;
    if (frame_end_i) begin
      since_d = '0;
    end else if (tick_en_i && (since_q != SAT)) begin
      since_d = since_q + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SAT;
    end else begin
      since_q <= since_d;
    end
  end

  assign gap_ok_o = (since_q == SAT);

  AST_GAP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> !gap_ok_o); // R6

endmodule

// File: rtl/pbm_sequencer.sv
module pbm_sequencer
  import pbm_pkg::*;
#(
  parameter int MAX_BITS   = 32,
  parameter int TICK_PAUSE = 30,
  parameter int TICK_ONE   = 150,
  parameter int TICK_ZERO  = 90
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_en_i,
  input  logic                         start_i,
  input  logic [MAX_BITS-1:0]          frame_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] nbits_i,
  input  logic                         ks_bit_i,
  input  logic                         gap_ok_i,
  output logic                         carrier_o,
  output logic                         ks_adv_o,
  output logic                         done_o,
  output logic                         frame_end_o
);

  localparam int NB_W      = $clog2(MAX_BITS + 1);
  localparam int IDX_W     = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam int CNT_W     = $clog2(TICK_ONE);
  localparam int MARK_ONE  = TICK_ONE - TICK_PAUSE;
  localparam int MARK_ZERO = TICK_ZERO - TICK_PAUSE;

  pbm_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [NB_W-1:0]     nbits_q, nbits_d;
  logic [MAX_BITS-1:0] frame_q, frame_d;
  logic                bit_q, bit_d;
  logic                carrier_q, carrier_d;
  logic                adv_q, adv_d;
  logic                done_q, done_d;
  logic                end_now;
  logic                pause_last;
  logic                mark_last;
  logic                bit_last;
  logic [NB_W-1:0]     nbits_clamped;

  assign nbits_clamped = (nbits_i > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : nbits_i;
  assign pause_last    = (cnt_q == CNT_W'(TICK_PAUSE - 1));
  assign mark_last     = bit_q ? (cnt_q == CNT_W'(MARK_ONE - 1))
                               : (cnt_q == CNT_W'(MARK_ZERO - 1));
  assign bit_last      = ((NB_W'(idx_q) + NB_W'(1)) == nbits_q);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    nbits_d   = nbits_q;
    frame_d   = frame_q;
    bit_d     = bit_q;
    carrier_d = carrier_q;
    adv_d     = 1'b0;
    done_d    = 1'b0;
    end_now   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        carrier_d = 1'b1;
        if (start_i) begin
          frame_d = frame_i;
          nbits_d = nbits_clamped;
          idx_d   = '0;
          cnt_d   = '0;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick_en_i && gap_ok_i) begin
          cnt_d     = '0;
          carrier_d = 1'b0;
          state_d   = (nbits_q == '0) ? ST_TAIL : ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (tick_en_i) begin
          if (pause_last) begin
            cnt_d     = '0;
            bit_d     = frame_q[idx_q] ^ ks_bit_i;
            carrier_d = 1'b1;
            state_d   = ST_MARK;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_MARK: begin
        if (tick_en_i) begin
          if (mark_last) begin
            cnt_d     = '0;
            adv_d     = 1'b1;
            carrier_d = 1'b0;
            if (bit_last) begin
              state_d = ST_TAIL;
            end else begin
              idx_d   = idx_q + IDX_W'(1);
              state_d = ST_PAUSE;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (tick_en_i) begin
          if (pause_last) begin
            cnt_d     = '0;
            carrier_d = 1'b1;
            done_d    = 1'b1;
            end_now   = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        state_d   = ST_IDLE;
        carrier_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      nbits_q   <= '0;
      frame_q   <= '0;
      bit_q     <= 1'b0;
      carrier_q <= 1'b1;
      adv_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      nbits_q   <= nbits_d;
      frame_q   <= frame_d;
      bit_q     <= bit_d;
      carrier_q <= carrier_d;
      adv_q     <= adv_d;
      done_q    <= done_d;
    end
  end

  assign carrier_o   = carrier_q;
  assign ks_adv_o    = adv_q;
  assign done_o      = done_q;
  assign frame_end_o = end_now;

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(carrier_q) |-> $past(tick_en_i)); // R11

  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_q |=> !adv_q); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> $stable(frame_q) && $stable(nbits_q)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MARK_ONE)); // R3

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MARK) |-> (NB_W'(idx_q) < nbits_q)); // R4

endmodule

// File: rtl/pause_bit_modulator.sv
module pause_bit_modulator #(
  parameter int MAX_BITS   = 32,
  parameter int TICK_PAUSE = 30,
  parameter int TICK_ONE   = 150,
  parameter int TICK_ZERO  = 90,
  parameter int TICK_GAP   = 330,
  parameter int TS_W       = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_en_i,
  input  logic                          start_i,
  input  logic [MAX_BITS-1:0]           frame_i,
  input  logic [$clog2(MAX_BITS+1)-1:0] nbits_i,
  input  logic                          ks_bit_i,
  output logic                          carrier_o,
  output logic                          ks_adv_o,
  output logic                          done_o,
  output logic [TS_W-1:0]               eof_ts_o
);

  logic gap_ok;
  logic frame_end;

  pbm_sequencer #(
    .MAX_BITS  (MAX_BITS),
    .TICK_PAUSE(TICK_PAUSE),
    .TICK_ONE  (TICK_ONE),
    .TICK_ZERO (TICK_ZERO)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en_i  (tick_en_i),
    .start_i    (start_i),
    .frame_i    (frame_i),
    .nbits_i    (nbits_i),
    .ks_bit_i   (ks_bit_i),
    .gap_ok_i   (gap_ok),
    .carrier_o  (carrier_o),
    .ks_adv_o   (ks_adv_o),
    .done_o     (done_o),
    .frame_end_o(frame_end)
  );

  pbm_gap_guard #(
    .TICK_GAP(TICK_GAP)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en_i  (tick_en_i),
    .frame_end_i(frame_end),
    .gap_ok_o   (gap_ok)
  );

  pbm_timebase #(
    .TS_W(TS_W)
  ) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en_i  (tick_en_i),
    .frame_end_i(frame_end),
    .eof_ts_o   (eof_ts_o)
  );

  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> carrier_o); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

endmodule

// File: tb/test_pause_bit_modulator.sv
module test_pause_bit_modulator;

  localparam int PAUSE = 30;
  localparam int ONE_T = 150;
  localparam int ZERO_T = 90;
  localparam int GAP = 330;
  localparam int NV = 7;
  localparam logic [31:0] VF [NV] = '{32'h0000_0001, 32'h0000_00A5, 32'hFFFF_FFFF,
                                      32'h0000_0000, 32'h1234_5678, 32'hDEAD_BEEF,
                                      32'h8000_0001};
  // entry 5 exercises R10 (zero bits), entry 6 exercises R12 (clamp of 40)
  localparam int VN [NV] = '{1, 8, 32, 32, 20, 0, 40};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en_i = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] frame_i = '0;
  logic [5:0]  nbits_i = '0;
  logic        ks_bit_i;
  logic        carrier_o, ks_adv_o, done_o;
  logic [31:0] eof_ts_o;

  int   checks = 0;
  int   failures = 0;
  int   tk = 1;
  int   seg_len [4096];
  bit   seg_lvl [4096];
  int   seg_n = 0;
  int   adv_cnt = 0;
  int   done_cnt = 0;
  logic [7:0] ks_lfsr = 8'h5B;

  always #2 clk = ~clk;

  assign ks_bit_i = ks_lfsr[0];

  pause_bit_modulator i_pause_bit_modulator (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .start_i(start_i),
    .frame_i(frame_i), .nbits_i(nbits_i), .ks_bit_i(ks_bit_i),
    .carrier_o(carrier_o), .ks_adv_o(ks_adv_o), .done_o(done_o), .eof_ts_o(eof_ts_o)
  );

  function automatic logic [7:0] step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // tick generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % tk;
      tick_en_i = (ph == 0);
    end
  end

  // line monitor and keystream model
  initial begin
    bit cur = 1'b1;
    int run = 0;
    forever begin
      @(negedge clk);
      if (ks_adv_o) begin adv_cnt++; ks_lfsr = step(ks_lfsr); end
      if (done_o) done_cnt++;
      if (carrier_o == cur) run++;
      else begin
        if (seg_n < 4096) begin seg_len[seg_n] = run; seg_lvl[seg_n] = cur; seg_n++; end
        cur = carrier_o;
        run = 1;
      end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic send(input logic [31:0] fr, input int nb, input bit chk_gap, input bit inject);
    int eff, a0, d0, base, t, bad_low, bad_bit, h, sum;
    logic [7:0] k;
    logic [31:0] ts0;
    bit b, eb;
    eff = (nb > 32) ? 32 : nb;
    a0 = adv_cnt; d0 = done_cnt; k = ks_lfsr; ts0 = eof_ts_o;
    @(negedge clk); start_i = 1'b1; frame_i = fr; nbits_i = 6'(nb);
    @(negedge clk); start_i = 1'b0;
    if (inject) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1; frame_i = ~fr; nbits_i = 6'd9;
      @(negedge clk); start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 40000) begin @(negedge clk); t++; end
    check(done_o, "R7 frame end pulse seen", done_o, 1);
    @(negedge clk); #1;
    base = seg_n - 1 - 2 * eff;
    bad_low = 0; bad_bit = 0; sum = 0;
    for (int i = 0; i <= eff; i++) begin
      if (seg_lvl[base + 2*i] != 1'b0 || seg_len[base + 2*i] != PAUSE * tk) bad_low++;
      if (i < eff) begin
        h = seg_len[base + 2*i + 1];
        b = (h == (ONE_T - PAUSE) * tk);
        if (!b && h != (ZERO_T - PAUSE) * tk) bad_bit++;
        eb = fr[i] ^ k[0];
        k = step(k);
        if (b != eb) bad_bit++;
        sum += eb ? ONE_T : ZERO_T;
      end
    end
    check(bad_low == 0, "R2 pause widths (mismatch count)", bad_low, 0);
    check(bad_bit == 0, "R3/R4/R5 decoded bits (mismatch count)", bad_bit, 0);
    check(adv_cnt - a0 == eff, "R5 keystream advances", adv_cnt - a0, eff);
    check(done_cnt - d0 == 1, "R7 done pulses", done_cnt - d0, 1);
    check(carrier_o == 1'b1, "R7 line high after tail", carrier_o, 1);
    if (nb == 0) check(adv_cnt == a0, "R10 no advance for empty frame", adv_cnt - a0, 0);
    if (nb > 32) check(eff == 32 && adv_cnt - a0 == 32, "R12 clamped bit count", adv_cnt - a0, 32);
    if (chk_gap) begin
      check(seg_len[base - 1] == GAP * tk, "R6 gap from previous end", seg_len[base - 1], GAP * tk);
      check(eof_ts_o - ts0 == 32'(GAP + sum + PAUSE), "R8 timestamp delta",
            eof_ts_o - ts0, GAP + sum + PAUSE);
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; failures++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int n, d, s;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(carrier_o == 1'b1, "R1 carrier in reset", carrier_o, 1);
    check(!ks_adv_o && !done_o, "R1 pulses low in reset", {ks_adv_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(carrier_o == 1'b1 && eof_ts_o == 0, "R1 idle after reset", eof_ts_o, 0);

    // vector table walked back to back
    for (int v = 0; v < NV; v++) send(VF[v], VN[v], v != 0, 1'b0);

    // R6 late start: gap already elapsed
    repeat (500) @(negedge clk);
    start_i = 1'b1; frame_i = 32'h1; nbits_i = 6'd1;
    n = 0;
    do begin @(negedge clk); start_i = 1'b0; n++; end while (carrier_o && n < 1000);
    check(n == 2, "R6 late start latency in clocks", n, 2);
    while (!done_o) @(negedge clk);
    repeat (2) @(negedge clk);

    // R9 start while busy ignored
    send(32'h0000_000B, 4, 1'b0, 1'b1);
    d = done_cnt; s = seg_n;
    repeat (600) @(negedge clk);
    check(done_cnt == d, "R9 no queued frame (done count)", done_cnt, d);
    check(seg_n == s && carrier_o, "R9 line stays high", seg_n, s);

    // R11 slowed tick
    tk = 3;
    send(32'h0000_0005, 3, 1'b0, 1'b0);
    check(seg_len[seg_n - 1] == 3 * PAUSE, "R11 tail width at 1/3 tick rate",
          seg_len[seg_n - 1], 3 * PAUSE);
    tk = 1;
    repeat (5) @(negedge clk);

    summary();
    $finish;
  end

endmodule